// File: doc/BRIEF.md
# Rotating-Window Register File with Overflow/Underflow Handshake

This block holds a large circular bank of physical registers and shows a routine only 32 of them at a time. Which 32 is decided by a current-window pointer. Logical registers are split into four groups of eight:

- shared globals, which are the same in every window;
- outs;
- locals;
- ins.

A save (call) moves the pointer forward one window, and a restore (return) moves it back. The outs of the caller and the ins of the callee are the same physical storage, so arguments pass between routines without any copy.

The block counts how many windows currently hold live contents. One window is always kept in reserve, so a callee's outs never land on live data. A save with no free window asks an external stack engine to spill the oldest resident window. A restore whose previous window is no longer resident asks the engine to fill it. While either request is open the block holds busy high and ignores further saves and restores until the engine acknowledges. The data transfer to memory is done outside this block.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, busy and both requests are low, and every logical register reads 0.
- R2: Logical register 0 always reads 0; writes addressed to it are dropped.
- R3: Logical registers 1..7 map to the same storage in every window.
- R4: A value written to logical out register 8+k in window w reads back as logical in register 24+k after a save into window w+1.
- R5: Logical registers 16..23 are private to each window: a save exposes different storage, and a later restore gives back the values written earlier.
- R6: Without a spill or fill, a save sets the pointer to (w+1) mod 8 at the next edge and a restore sets it to (w-1) mod 8. When save and restore arrive together, the save wins.
- R7: A save while 7 windows are resident leaves the pointer unchanged, raises spill request with transfer window (w+2) mod 8, and holds busy. The acknowledge advances the pointer by one, and the resident count stays at 7.
- R8: A restore while only the current window is resident raises fill request with transfer window (w-1) mod 8 and holds busy. The acknowledge moves the pointer back by one, and the resident count stays at 1.
- R9: While a request is open without acknowledge, the pointer, the request and the transfer window hold steady, and save/restore strobes have no effect. Spill and fill requests are never high together.
- R10: A write in the same cycle as a save or restore goes to the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | 5 | Logical address, read port A |
| rd_data_a_o | output | 32 | Read data A (combinational) |
| rd_addr_b_i | input | 5 | Logical address, read port B |
| rd_data_b_o | output | 32 | Read data B (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical write address |
| wr_data_i | input | 32 | Write data |
| save_i | input | 1 | Call strobe: advance window |
| restore_i | input | 1 | Return strobe: retreat window |
| busy_o | output | 1 | Spill or fill outstanding |
| spill_req_o | output | 1 | Request to spill a window to the stack |
| fill_req_o | output | 1 | Request to fill a window from the stack |
| xfer_win_o | output | 3 | Window index to spill or fill |
| xfer_ack_i | input | 1 | Stack engine done |
| cwp_o | output | 3 | Current window pointer |

## Verification
A register write and a window move can fall in the same clock edge, and so can the two window strobes. The bench writes an out register in the very cycle it pulses save. It judges the result by reading the callee's matching in register, which only holds the value if the write used the pre-move window. It also pulses save and restore together, and pulses them during an open spill, then checks the pointer against the count kept arithmetically in the bench.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wrf_state_e;
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter int NWIN = 8,
  parameter int GRP  = 8,
  localparam int GW   = $clog2(GRP),
  localparam int LW   = GW + 2,
  localparam int CW   = $clog2(NWIN),
  localparam int PHYS = GRP + NWIN * 2 * GRP,
  localparam int PW   = $clog2(PHYS)
) (
  input  logic [CW-1:0] cwp_i,
  input  logic [LW-1:0] log_i,
  output logic [PW-1:0] phys_o
);
  logic [1:0]    grp;
  logic [GW-1:0] off;
  logic [CW-1:0] cwp_nxt;
  logic [PW-1:0] base_cur, base_nxt;

  assign grp      = log_i[LW-1 -: 2];
  assign off      = log_i[GW-1:0];
  assign cwp_nxt  = cwp_i + CW'(1);
  assign base_cur = PW'(GRP) + PW'(cwp_i) * PW'(2 * GRP);
  assign base_nxt = PW'(GRP) + PW'(cwp_nxt) * PW'(2 * GRP);

  // window block layout: [locals][ins]; outs alias the next window's ins
  always_comb begin
    case (grp)
      2'd0:    phys_o = PW'(off);
      2'd1:    phys_o = base_nxt + PW'(GRP) + PW'(off);
      2'd2:    phys_o = base_cur + PW'(off);
      default: phys_o = base_cur + PW'(GRP) + PW'(off);
    endcase
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DW   = 32,
  parameter int PHYS = 136,
  parameter int NRD  = 2,
  localparam int PW  = $clog2(PHYS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [PW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [NRD-1:0][PW-1:0]  ra_i,
  output logic [NRD-1:0][DW-1:0]  rd_o
);
  logic [DW-1:0] mem_q [PHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = (ra_i[p] == '0) ? '0 : mem_q[ra_i[p]];
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN),
  localparam int RW  = $clog2(NWIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic          xfer_ack_i,
  output logic [CW-1:0] cwp_o,
  output logic          busy_o,
  output logic          spill_req_o,
  output logic          fill_req_o,
  output logic [CW-1:0] xfer_win_o
);
  wrf_state_e    state_q;
  logic [CW-1:0] cwp_q, win_q;
  logic [RW-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cwp_q   <= '0;
      win_q   <= '0;
      res_q   <= RW'(1);
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (save_i) begin
            if (res_q == RW'(NWIN - 1)) begin
              state_q <= ST_SPILL;
              win_q   <= cwp_q - CW'(res_q) + CW'(1); // oldest resident
            end else begin
              cwp_q <= cwp_q + CW'(1);
              res_q <= res_q + RW'(1);
            end
          end else if (restore_i) begin
            if (res_q == RW'(1)) begin
              state_q <= ST_FILL;
              win_q   <= cwp_q - CW'(1);
            end else begin
              cwp_q <= cwp_q - CW'(1);
              res_q <= res_q - RW'(1);
            end
          end
        end
        ST_SPILL: if (xfer_ack_i) begin
          state_q <= ST_IDLE;
          cwp_q   <= cwp_q + CW'(1); // spill -1, save +1: count unchanged
        end
        ST_FILL: if (xfer_ack_i) begin
          state_q <= ST_IDLE;
          cwp_q   <= cwp_q - CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cwp_o       = cwp_q;
  assign xfer_win_o  = win_q;
  assign spill_req_o = (state_q == ST_SPILL);
  assign fill_req_o  = (state_q == ST_FILL);
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int GRP  = 8,
  parameter int DW   = 32,
  localparam int GW   = $clog2(GRP),
  localparam int LW   = GW + 2,
  localparam int CW   = $clog2(NWIN),
  localparam int PHYS = GRP + NWIN * 2 * GRP,
  localparam int PW   = $clog2(PHYS),
  localparam int NPRT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] rd_addr_a_i,
  output logic [DW-1:0] rd_data_a_o,
  input  logic [LW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          save_i,
  input  logic          restore_i,
  output logic          busy_o,
  output logic          spill_req_o,
  output logic          fill_req_o,
  output logic [CW-1:0] xfer_win_o,
  input  logic          xfer_ack_i,
  output logic [CW-1:0] cwp_o
);
  logic [CW-1:0]              cwp;
  logic [NPRT-1:0][LW-1:0]    log_addr;
  logic [NPRT-1:0][PW-1:0]    phys_addr;
  logic [1:0][DW-1:0]         rd_data;

  assign log_addr[0] = rd_addr_a_i;
  assign log_addr[1] = rd_addr_b_i;
  assign log_addr[2] = wr_addr_i;

  wrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_i      (save_i),
    .restore_i   (restore_i),
    .xfer_ack_i  (xfer_ack_i),
    .cwp_o       (cwp),
    .busy_o      (busy_o),
    .spill_req_o (spill_req_o),
    .fill_req_o  (fill_req_o),
    .xfer_win_o  (xfer_win_o)
  );

  for (genvar p = 0; p < NPRT; p++) begin : g_map
    wrf_map #(.NWIN(NWIN), .GRP(GRP)) u_map (
      .cwp_i  (cwp),
      .log_i  (log_addr[p]),
      .phys_o (phys_addr[p])
    );
  end

  wrf_store #(.DW(DW), .PHYS(PHYS), .NRD(2)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .wa_i   (phys_addr[2]),
    .wd_i   (wr_data_i),
    .ra_i   (phys_addr[1:0]),
    .rd_o   (rd_data)
  );

  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];
  assign cwp_o       = cwp;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int CW = 3,
  parameter int LW = 5,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          save_i,
  input logic          restore_i,
  input logic          xfer_ack_i,
  input logic          spill_req_o,
  input logic          fill_req_o,
  input logic          busy_o,
  input logic [CW-1:0] xfer_win_o,
  input logic [CW-1:0] cwp_o,
  input logic [LW-1:0] rd_addr_a_i,
  input logic [DW-1:0] rd_data_a_o
);
  assert_req_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spill_req_o && fill_req_o));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((spill_req_o || fill_req_o) && !xfer_ack_i) |=>
      ($stable(cwp_o) && $stable(xfer_win_o) && $stable(spill_req_o) && $stable(fill_req_o)));

  assert_spill_adv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_req_o && xfer_ack_i) |=> (cwp_o == $past(cwp_o) + CW'(1)) && !busy_o);

  assert_fill_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && xfer_ack_i) |=> (cwp_o == $past(cwp_o) - CW'(1)) && !busy_o);

  assert_save_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && save_i) |=> (cwp_o == $past(cwp_o) + CW'(1)) || spill_req_o);

  assert_zero_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));
endmodule

bind win_regfile win_regfile_chk #(.CW(CW), .LW(LW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .xfer_ack_i  (xfer_ack_i),
  .spill_req_o (spill_req_o),
  .fill_req_o  (fill_req_o),
  .busy_o      (busy_o),
  .xfer_win_o  (xfer_win_o),
  .cwp_o       (cwp_o),
  .rd_addr_a_i (rd_addr_a_i),
  .rd_data_a_o (rd_data_a_o)
);

// File: tb/sim_win_regfile.sv
module sim_win_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_addr_a_i = '0, rd_addr_b_i = '0, wr_addr_i = '0;
  logic [31:0] rd_data_a_o, rd_data_b_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, save_i = 1'b0, restore_i = 1'b0, xfer_ack_i = 1'b0;
  logic        busy_o, spill_req_o, fill_req_o;
  logic [2:0]  xfer_win_o, cwp_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  win_regfile u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; #3; step(); rst_ni = 1'b1; step();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; step(); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr_a_i = a; rd_addr_b_i = a; #1; d = rd_data_a_o;
  endtask

  task automatic save();    save_i = 1'b1; step(); save_i = 1'b0; endtask
  task automatic restore(); restore_i = 1'b1; step(); restore_i = 1'b0; endtask
  task automatic ack();     xfer_ack_i = 1'b1; step(); xfer_ack_i = 1'b0; endtask

  function automatic logic [31:0] out_v(int w, int k);   return 32'hA000 + 32'(w * 256 + k); endfunction
  function automatic logic [31:0] loc_v(int w, int k);   return 32'hB000 + 32'(w * 256 + k); endfunction
  function automatic logic [31:0] glb_v(int k);          return 32'hC000 + 32'(k); endfunction

  initial begin
    logic [31:0] d;
    do_reset();
    // R1: reset state, all logical registers zero on both ports
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 busy/req", {29'd0, busy_o, spill_req_o, fill_req_o}, 0);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d); chk("R1 read A", d, 0); chk("R1 read B", rd_data_b_o, 0);
    end
    // R2: writes to register 0 dropped
    wr(5'd0, 32'hDEAD_BEEF); rd(5'd0, d); chk("R2 zero reg", d, 0);
    for (int k = 1; k < 8; k++) wr(5'(k), glb_v(k));

    // R3/R4/R5/R6: climb windows 0..5 without spill
    for (int w = 0; w < 6; w++) begin
      for (int k = 0; k < 8; k++) begin
        wr(5'(16 + k), loc_v(w, k));
        wr(5'(8 + k), out_v(w, k));
      end
      save();
      chk("R6 save step", 32'(cwp_o), 32'(w + 1));
      chk("R6 no busy", 32'(busy_o), 0);
      for (int k = 0; k < 8; k++) begin
        rd(5'(24 + k), d); chk("R4 outs->ins", d, out_v(w, k));
        rd(5'(16 + k), d); chk("R5 fresh locals", d, 0);
      end
      for (int k = 1; k < 8; k++) begin
        rd(5'(k), d); chk("R3 globals", d, glb_v(k));
      end
    end
    for (int k = 0; k < 8; k++) wr(5'(16 + k), loc_v(6, k));
    // descend back to 0 with restores, locals and ins preserved
    for (int w = 6; w > 0; w--) begin
      for (int k = 0; k < 8; k++) begin
        rd(5'(16 + k), d); chk("R5 locals kept", d, loc_v(w, k));
        rd(5'(24 + k), d); chk("R4 ins kept", d, out_v(w - 1, k));
      end
      restore();
      chk("R6 restore step", 32'(cwp_o), 32'(w - 1));
    end
    for (int k = 0; k < 8; k++) begin
      rd(5'(16 + k), d); chk("R5 window0 locals", d, loc_v(0, k));
    end

    // R6: save and restore together -> save wins; restore wraps 0 -> 7 needs fill here
    save_i = 1'b1; restore_i = 1'b1; step(); save_i = 1'b0; restore_i = 1'b0;
    chk("R6 save priority", 32'(cwp_o), 1);

    // R10: write out register in the save cycle
    do_reset();
    wr_en_i = 1'b1; wr_addr_i = 5'd9; wr_data_i = 32'h1234_5678; save_i = 1'b1;
    step(); wr_en_i = 1'b0; save_i = 1'b0;
    rd(5'd25, d); chk("R10 write in save cycle", d, 32'h1234_5678);
    rd(5'd9, d);  chk("R10 new outs untouched", d, 0);
    wr_en_i = 1'b1; wr_addr_i = 5'd17; wr_data_i = 32'h0BAD_F00D; restore_i = 1'b1;
    step(); wr_en_i = 1'b0; restore_i = 1'b0;
    rd(5'd17, d); chk("R10 write in restore cycle", d, 0);
    save();
    rd(5'd17, d); chk("R10 write landed in old window", d, 32'h0BAD_F00D);

    // R7/R9: spill path
    do_reset();
    for (int i = 0; i < 6; i++) save();
    chk("R7 pre-spill cwp", 32'(cwp_o), 6);
    save();
    chk("R7 spill req", 32'(spill_req_o), 1);
    chk("R7 busy", 32'(busy_o), 1);
    chk("R7 spill window", 32'(xfer_win_o), 0);
    chk("R7 cwp held", 32'(cwp_o), 6);
    restore(); save(); step();
    chk("R9 strobes ignored", 32'(cwp_o), 6);
    chk("R9 req held", 32'(spill_req_o), 1);
    chk("R9 win held", 32'(xfer_win_o), 0);
    chk("R9 no fill", 32'(fill_req_o), 0);
    ack();
    chk("R7 cwp after ack", 32'(cwp_o), 7);
    chk("R7 busy cleared", 32'(busy_o), 0);
    save();
    chk("R7 second spill", 32'(spill_req_o), 1);
    chk("R7 second window", 32'(xfer_win_o), 1);
    ack();
    chk("R7 wrap to 0", 32'(cwp_o), 0);

    // R8: fill path (7 resident, cwp 0)
    for (int i = 0; i < 6; i++) restore();
    chk("R6 restore wrap", 32'(cwp_o), 2);
    chk("R8 no fill yet", 32'(fill_req_o), 0);
    restore();
    chk("R8 fill req", 32'(fill_req_o), 1);
    chk("R8 fill window", 32'(xfer_win_o), 1);
    chk("R8 cwp held", 32'(cwp_o), 2);
    save(); step();
    chk("R9 save ignored in fill", 32'(cwp_o), 2);
    ack();
    chk("R8 cwp after ack", 32'(cwp_o), 1);
    restore();
    chk("R8 second fill", 32'(fill_req_o), 1);
    chk("R8 second window", 32'(xfer_win_o), 0);
    ack();
    chk("R8 cwp 0", 32'(cwp_o), 0);
    save();
    chk("R6 save after fills", 32'(cwp_o), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule